// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block empties a sector buffer toward one of several consumers. Software first loads a 16-bit data address counter and a 12-bit byte counter. It then writes a trigger together with a 3-bit destination code. Two codes give word-wise reads by one of two host processors. Three codes give a paced byte stream (DMA) into one of three destination memories. The buffer is external and is read through a word-wide synchronous port with one cycle of latency. The destinations are reached through a byte write port with valid/ready handshaking and a target tag.

The byte counter works one past zero: a transfer moves count+1 bytes and ends when the counter drops below zero as a signed value. The counter then reads all ones. Host mode keeps one word prefetched. DMA is paced by a credit timer and moves bursts of up to eight bytes. A DMA toward a memory that the other processor currently owns waits in a halted state until that memory is released. The end of a transfer raises a ready/end flag pair for the host, leaves a transfer-end pending bit, and produces an interrupt edge toward the interrupt logic when the rules allow it.

Top module: `xfer_engine`

## Requirements
- R1: After reset, busy, flag_ready, flag_end, wr_valid and end_pend are 0, and addr_q and cnt_q are 0.
- R2: A trigger while dout_en is 0 does nothing: the flags keep their values, busy stays 0 and no byte is written.
- R3: In host mode (code 2 for host 0, code 3 for host 1), each fetch reads the buffer word at addr_q with bit 0 ignored and the address taken modulo the 16 KB buffer. The even byte goes to host_word[15:8]. The fetch then adds 2 to addr_q, subtracts 2 from cnt_q and sets flag_ready.
- R4: A host read pulse is taken only from the host that matches the active host code while flag_ready is 1. host_word keeps the latched word at the read, and the next word is then fetched.
- R5: When the count falls below zero, cnt_q becomes 0xFFFF, busy falls, flag_end rises and end_pend is set. A transfer loaded with count N therefore moves N+1 bytes in DMA mode, or floor(N/2)+1 words in host mode.
- R6: A host read that is taken while flag_end is 1 clears flag_ready and fetches nothing, so addr_q and host_word stay unchanged.
- R7: A DMA writes the bytes of successive byte addresses, starting at addr_q, in increasing order. wr_addr is the 16-bit address and wr_data the buffer byte. A write held by wr_ready=0 keeps wr_addr and wr_data stable. At the end, flag_ready is 0 and flag_end is 1.
- R8: DMA bytes move in bursts of at most BURST_LEN. The first byte comes no sooner than BURST_LEN*CYC_PER_BYTE cycles after the trigger. Successive burst starts are at least that far apart.
- R9: wr_tgt encodes the destination: code 4 gives 0, code 5 gives 1, and code 7 gives 4 when word_split is 0. When word_split is 1, code 7 gives 2 if bank_sel is 1 and 3 if bank_sel is 0.
- R10: Code 5 while own_prg is 1, or code 7 with word_split 0 while own_word is 1, parks the transfer: halted is 1, busy is 1 and nothing is written. The transfer resumes by itself once the owner releases the memory.
- R11: Codes 0, 1 and 6 clear both flags and start nothing: busy stays 0, and the counters and the write port are untouched.
- R12: Dropping dout_en ends any transfer at once. busy falls, no further byte is written and flag_end is not set.
- R13: end_pend is set at every transfer end and cleared by end_ack. With end_ie set, the end raises a one-cycle irq_edge only if no earlier transfer-end interrupt is still unacknowledged and the decoder source is inactive. A decoder source that is pending but already expired gets a dec_clr pulse and does not block the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dout_en | input | 1 | Data output enable; low aborts and blocks triggers |
| trig | input | 1 | Start pulse |
| dest_code | input | 3 | Destination code sampled with trig |
| addr_ld | input | 1 | Load the data address counter |
| addr_val | input | 16 | Address load value |
| cnt_ld | input | 1 | Load the byte counter |
| cnt_val | input | 12 | Count load value |
| own_prg | input | 1 | Program memory held by the other processor |
| own_word | input | 1 | Whole word memory held by the other processor |
| word_split | input | 1 | Word memory in split-bank mode |
| bank_sel | input | 1 | Bank choice in split-bank mode |
| host_rd | input | 1 | Host data read pulse |
| host_sub | input | 1 | Which host reads: 0 host 0, 1 host 1 |
| host_word | output | 16 | Latched host word |
| buf_re | output | 1 | Buffer read enable |
| buf_raddr | output | 13 | Buffer word address |
| buf_rdata | input | 16 | Buffer word, one cycle after buf_re |
| wr_valid | output | 1 | Destination byte valid |
| wr_ready | input | 1 | Destination accepts byte |
| wr_tgt | output | 3 | Destination tag |
| wr_addr | output | 16 | Destination byte address |
| wr_data | output | 8 | Destination byte |
| busy | output | 1 | Transfer running or halted |
| halted | output | 1 | Waiting for memory release |
| flag_ready | output | 1 | Host word ready flag |
| flag_end | output | 1 | Transfer end flag |
| addr_q | output | 16 | Data address counter |
| cnt_q | output | 16 | Byte counter |
| end_ie | input | 1 | Transfer-end interrupt enable |
| end_ack | input | 1 | Acknowledge transfer end |
| dec_pend | input | 1 | Decoder interrupt source active |
| dec_expired | input | 1 | Decoder active period has passed |
| end_pend | output | 1 | Transfer end pending |
| dec_clr | output | 1 | Pulse clearing an expired decoder source |
| irq_edge | output | 1 | Interrupt edge pulse |

## Verification
The bench builds the engine with CYC_PER_BYTE of 4 and BURST_LEN of 8, with the 16 KB buffer width left as is. The burst period is therefore 32 cycles, and an 11-byte DMA shows a full burst followed by a short final burst within a few hundred cycles. It also shows the gap between burst starts against the tight spacing of bytes inside a burst. The full 14-bit buffer address lets the bench start a host transfer at 0xFFFE and see the buffer address wrap while the 16-bit counter rolls over to zero.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    TGT_PCM   = 3'd0,
    TGT_PRG   = 3'd1,
    TGT_WB0   = 3'd2,
    TGT_WB1   = 3'd3,
    TGT_WFULL = 3'd4
  } tgt_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_HCAP, S_HWAIT,
    S_HALT, S_PACE, S_DRD, S_DCAP, S_DWR
  } st_e;

  localparam logic [2:0] CODE_HOST0 = 3'd2;
  localparam logic [2:0] CODE_HOST1 = 3'd3;
  localparam logic [2:0] CODE_PCM   = 3'd4;
  localparam logic [2:0] CODE_PRG   = 3'd5;
  localparam logic [2:0] CODE_WORD  = 3'd7;
endpackage

// File: rtl/xfer_counters.sv
module xfer_counters #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              step_host,
  input  logic              step_byte,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              last_host,
  output logic              last_byte
);
  logic [ADDR_W-1:0] dec2, dec1;

  assign dec2      = cnt_q - ADDR_W'(2);
  assign dec1      = cnt_q - ADDR_W'(1);
  assign last_host = dec2[ADDR_W-1];
  assign last_byte = dec1[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (step_host)      addr_q <= addr_q + ADDR_W'(2);
      else if (step_byte) addr_q <= addr_q + ADDR_W'(1);
      else if (addr_ld)   addr_q <= addr_val;

      if (step_host)      cnt_q <= last_host ? '1 : dec2;
      else if (step_byte) cnt_q <= last_byte ? '1 : dec1;
      else if (cnt_ld)    cnt_q <= ADDR_W'(cnt_val);
    end
  end
endmodule

// File: rtl/xfer_pacer.sv
module xfer_pacer #(
  parameter int BURST_CYC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic take,
  output logic ok
);
  localparam int CW = $clog2(BURST_CYC + 1);
  logic [CW-1:0] credit;

  assign ok = (credit == CW'(BURST_CYC));

  always_ff @(posedge clk) begin
    if (rst || clr)      credit <= '0;
    else if (take)       credit <= '0;
    else if (run && !ok) credit <= credit + CW'(1);
  end
endmodule

// File: rtl/xfer_irq.sv
module xfer_irq (
  input  logic clk,
  input  logic rst,
  input  logic end_evt,
  input  logic end_ie,
  input  logic end_ack,
  input  logic dec_pend,
  input  logic dec_expired,
  output logic end_pend,
  output logic dec_clr,
  output logic irq_edge
);
  logic end_act;
  logic dec_live;

  assign dec_live = dec_pend && !dec_expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      end_pend <= 1'b0;
      end_act  <= 1'b0;
      dec_clr  <= 1'b0;
      irq_edge <= 1'b0;
    end else begin
      dec_clr  <= end_evt && end_ie && dec_pend && dec_expired;
      irq_edge <= end_evt && end_ie && !end_act && !dec_live;
      if (end_evt) begin
        end_pend <= 1'b1;
        if (end_ie) end_act <= 1'b1;
      end else if (end_ack) begin
        end_pend <= 1'b0;
        end_act  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 12,
  parameter int BUF_AW       = 14,
  parameter int CYC_PER_BYTE = 16,
  parameter int BURST_LEN    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dout_en,
  input  logic                trig,
  input  logic [2:0]          dest_code,
  input  logic                addr_ld,
  input  logic [ADDR_W-1:0]   addr_val,
  input  logic                cnt_ld,
  input  logic [CNT_W-1:0]    cnt_val,
  input  logic                own_prg,
  input  logic                own_word,
  input  logic                word_split,
  input  logic                bank_sel,
  input  logic                host_rd,
  input  logic                host_sub,
  output logic [15:0]         host_word,
  output logic                buf_re,
  output logic [BUF_AW-2:0]   buf_raddr,
  input  logic [15:0]         buf_rdata,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [2:0]          wr_tgt,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [7:0]          wr_data,
  output logic                busy,
  output logic                halted,
  output logic                flag_ready,
  output logic                flag_end,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [ADDR_W-1:0]   cnt_q,
  input  logic                end_ie,
  input  logic                end_ack,
  input  logic                dec_pend,
  input  logic                dec_expired,
  output logic                end_pend,
  output logic                dec_clr,
  output logic                irq_edge
);
  localparam int BURST_CYC = CYC_PER_BYTE * BURST_LEN;
  localparam int BL_W      = $clog2(BURST_LEN + 1);

  st_e            st;
  tgt_e           tgt_q;
  logic           host_mode, host_is_sub;
  logic [BL_W-1:0] burst_left;
  logic           last_host, last_byte;
  logic           step_host, step_byte, go;
  logic           pace_ok, pace_run, pace_clr, pace_take;
  logic           host_ok, release_now, end_evt;
  logic           code_host, code_dma, code_hold;
  tgt_e           code_tgt;

  // destination decode for the trigger cycle
  always_comb begin
    code_host = (dest_code == CODE_HOST0) || (dest_code == CODE_HOST1);
    code_dma  = 1'b1;
    code_hold = 1'b0;
    code_tgt  = TGT_PCM;
    case (dest_code)
      CODE_PCM: code_tgt = TGT_PCM;
      CODE_PRG: begin
        code_tgt  = TGT_PRG;
        code_hold = own_prg;
      end
      CODE_WORD: begin
        if (word_split) code_tgt = bank_sel ? TGT_WB0 : TGT_WB1;
        else begin
          code_tgt  = TGT_WFULL;
          code_hold = own_word;
        end
      end
      default: code_dma = 1'b0;
    endcase
  end

  assign go          = dout_en && !trig;
  assign step_host   = go && (st == S_HCAP);
  assign step_byte   = go && (st == S_DWR) && wr_ready;
  assign host_ok     = host_rd && host_mode && (host_sub == host_is_sub) && flag_ready;
  assign release_now = (tgt_q == TGT_PRG) ? !own_prg : !own_word;
  assign end_evt     = (step_host && last_host) || (step_byte && last_byte);

  assign pace_clr  = trig || (st == S_HALT);
  assign pace_run  = (st == S_PACE) || (st == S_DRD) || (st == S_DCAP) || (st == S_DWR);
  assign pace_take = go && (st == S_PACE) && pace_ok;

  assign buf_re    = (st == S_HREQ) || (st == S_DRD);
  assign buf_raddr = addr_q[BUF_AW-1:1];
  assign wr_valid  = (st == S_DWR);
  assign wr_addr   = addr_q;
  assign wr_tgt    = tgt_q;
  assign halted    = (st == S_HALT);

  xfer_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst),
    .addr_ld(addr_ld), .addr_val(addr_val),
    .cnt_ld(cnt_ld), .cnt_val(cnt_val),
    .step_host(step_host), .step_byte(step_byte),
    .addr_q(addr_q), .cnt_q(cnt_q),
    .last_host(last_host), .last_byte(last_byte)
  );

  xfer_pacer #(.BURST_CYC(BURST_CYC)) i_pace (
    .clk(clk), .rst(rst), .clr(pace_clr), .run(pace_run),
    .take(pace_take), .ok(pace_ok)
  );

  xfer_irq i_irq (
    .clk(clk), .rst(rst), .end_evt(end_evt), .end_ie(end_ie),
    .end_ack(end_ack), .dec_pend(dec_pend), .dec_expired(dec_expired),
    .end_pend(end_pend), .dec_clr(dec_clr), .irq_edge(irq_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      tgt_q       <= TGT_PCM;
      host_mode   <= 1'b0;
      host_is_sub <= 1'b0;
      burst_left  <= '0;
      busy        <= 1'b0;
      flag_ready  <= 1'b0;
      flag_end    <= 1'b0;
      host_word   <= '0;
      wr_data     <= '0;
    end else if (!dout_en) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      host_mode <= 1'b0;
    end else if (trig) begin
      flag_ready <= 1'b0;
      flag_end   <= 1'b0;
      host_mode  <= 1'b0;
      if (code_host) begin
        st          <= S_HREQ;
        busy        <= 1'b1;
        host_mode   <= 1'b1;
        host_is_sub <= dest_code[0];
      end else if (code_dma) begin
        st    <= code_hold ? S_HALT : S_PACE;
        busy  <= 1'b1;
        tgt_q <= code_tgt;
      end else begin
        st   <= S_IDLE;
        busy <= 1'b0;
      end
    end else begin
      case (st)
        S_IDLE, S_HWAIT: begin
          if (host_ok) begin
            if (flag_end) flag_ready <= 1'b0;
            else          st <= S_HREQ;
          end
        end
        S_HREQ: st <= S_HCAP;
        S_HCAP: begin
          host_word  <= buf_rdata;
          flag_ready <= 1'b1;
          if (last_host) begin
            flag_end <= 1'b1;
            busy     <= 1'b0;
            st       <= S_IDLE;
          end else begin
            st <= S_HWAIT;
          end
        end
        S_HALT: if (release_now) st <= S_PACE;
        S_PACE: begin
          if (pace_ok) begin
            burst_left <= BL_W'(BURST_LEN);
            st         <= S_DRD;
          end
        end
        S_DRD: st <= S_DCAP;
        S_DCAP: begin
          wr_data <= addr_q[0] ? buf_rdata[7:0] : buf_rdata[15:8];
          st      <= S_DWR;
        end
        S_DWR: begin
          if (wr_ready) begin
            burst_left <= burst_left - BL_W'(1);
            if (last_byte) begin
              flag_end   <= 1'b1;
              flag_ready <= 1'b0;
              busy       <= 1'b0;
              st         <= S_IDLE;
            end else if (burst_left == BL_W'(1)) begin
              st <= S_PACE;
            end else begin
              st <= S_DRD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int ADDR_W    = 16,
  parameter int BURST_CYC = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              dout_en,
  input logic              trig,
  input logic [2:0]        dest_code,
  input logic              host_rd,
  input logic              busy,
  input logic              flag_ready,
  input logic              flag_end,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] cnt_q,
  input logic              end_pend,
  input logic              irq_edge
);
  localparam int SW = $clog2(BURST_CYC + 2) + 1;
  logic [SW-1:0] since_trig;
  logic          bad_code;

  assign bad_code = (dest_code == 3'd0) || (dest_code == 3'd1) || (dest_code == 3'd6);

  always_ff @(posedge clk) begin
    if (rst || (trig && dout_en)) since_trig <= '0;
    else if (since_trig != '1)    since_trig <= since_trig + SW'(1);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!busy && !flag_end && !flag_ready && !wr_valid && !end_pend));

  assert_trig_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (trig && !dout_en && !busy && !host_rd) |=> ($stable(flag_end) && $stable(flag_ready)));

  assert_end_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_end) |-> (cnt_q == '1));

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && dout_en && !trig) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_pace_first_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (since_trig >= SW'(BURST_CYC)));

  assert_invalid_code_R11: assert property (@(posedge clk) disable iff (rst)
    (trig && dout_en && bad_code) |=> (!busy && !flag_end && !wr_valid));

  assert_abort_R12: assert property (@(posedge clk) disable iff (rst)
    !dout_en |=> (!busy && !wr_valid));

  assert_edge_pend_R13: assert property (@(posedge clk) disable iff (rst)
    irq_edge |-> end_pend);
endmodule

bind xfer_engine xfer_engine_chk #(
  .ADDR_W(ADDR_W),
  .BURST_CYC(CYC_PER_BYTE * BURST_LEN)
) i_chk (.*);

// File: tb/test_xfer_engine.sv
`timescale 1ns/1ps
module test_xfer_engine;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;
  localparam int BUF_AW = 14;
  localparam int CPB    = 4;
  localparam int BL     = 8;
  localparam int BCYC   = CPB * BL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dout_en = 1'b1, trig = 1'b0;
  logic [2:0] dest_code = 3'd0;
  logic addr_ld = 1'b0, cnt_ld = 1'b0;
  logic [ADDR_W-1:0] addr_val = '0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic own_prg = 1'b0, own_word = 1'b0, word_split = 1'b0, bank_sel = 1'b0;
  logic host_rd = 1'b0, host_sub = 1'b0;
  logic [15:0] host_word;
  logic buf_re;
  logic [BUF_AW-2:0] buf_raddr;
  logic [15:0] buf_rdata = '0;
  logic wr_valid, wr_ready = 1'b1;
  logic [2:0] wr_tgt;
  logic [ADDR_W-1:0] wr_addr, addr_q, cnt_q;
  logic [7:0] wr_data;
  logic busy, halted, flag_ready, flag_end;
  logic end_ie = 1'b0, end_ack = 1'b0, dec_pend = 1'b0, dec_expired = 1'b0;
  logic end_pend, dec_clr, irq_edge;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nw = 0, n_edge = 0, n_dclr = 0, t_trig = 0;
  bit stall = 0, stall_ph = 0;
  logic [15:0] wl_a [0:63];
  logic [7:0]  wl_d [0:63];
  logic [2:0]  wl_g [0:63];
  int          wl_t [0:63];

  xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW),
                .CYC_PER_BYTE(CPB), .BURST_LEN(BL)) i_xfer_engine (
    .clk(clk), .rst(rst), .dout_en(dout_en), .trig(trig), .dest_code(dest_code),
    .addr_ld(addr_ld), .addr_val(addr_val), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
    .own_prg(own_prg), .own_word(own_word), .word_split(word_split), .bank_sel(bank_sel),
    .host_rd(host_rd), .host_sub(host_sub), .host_word(host_word),
    .buf_re(buf_re), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .halted(halted), .flag_ready(flag_ready),
    .flag_end(flag_end), .addr_q(addr_q), .cnt_q(cnt_q), .end_ie(end_ie),
    .end_ack(end_ack), .dec_pend(dec_pend), .dec_expired(dec_expired),
    .end_pend(end_pend), .dec_clr(dec_clr), .irq_edge(irq_edge)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] bb(input logic [13:0] a);
    logic [7:0] lo, hi;
    lo = a[7:0];
    hi = {2'b00, a[13:8]};
    return lo * 8'd37 + hi * 8'd11 + 8'h5C;
  endfunction

  function automatic logic [15:0] bw(input logic [15:0] a);
    logic [13:0] e;
    e = {a[13:1], 1'b0};
    return {bb(e), bb(e | 14'd1)};
  endfunction

  always @(posedge clk) if (buf_re) buf_rdata <= {bb({buf_raddr, 1'b0}), bb({buf_raddr, 1'b1})};

  always @(negedge clk) begin
    stall_ph = ~stall_ph;
    wr_ready = stall ? stall_ph : 1'b1;
    if (wr_valid && wr_ready && nw < 64) begin
      wl_a[nw] = wr_addr; wl_d[nw] = wr_data; wl_g[nw] = wr_tgt; wl_t[nw] = cyc;
      nw = nw + 1;
    end
    if (irq_edge) n_edge = n_edge + 1;
    if (dec_clr)  n_dclr = n_dclr + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic [11:0] c);
    @(negedge clk);
    addr_ld = 1; addr_val = a; cnt_ld = 1; cnt_val = c;
    @(negedge clk);
    addr_ld = 0; cnt_ld = 0;
  endtask

  task automatic fire(input logic [2:0] code);
    dest_code = code; trig = 1; t_trig = cyc;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic hread(input logic sub);
    host_sub = sub; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic ack();
    end_ack = 1;
    @(negedge clk);
    end_ack = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    step(2);
  endtask

  task automatic t_reset();
    chk(!busy && !flag_end && !flag_ready, "R1", "flags", {busy, flag_end, flag_ready}, 0);
    chk(!wr_valid && !end_pend, "R1", "wr_valid/end_pend", {wr_valid, end_pend}, 0);
    chk(addr_q == 0 && cnt_q == 0, "R1", "counters", {addr_q, cnt_q}, 0);
  endtask

  task automatic t_host();
    logic [15:0] w0;
    load(16'h0101, 12'd3); fire(3'd2); step(6);
    w0 = bw(16'h0100);
    chk(host_word == w0, "R3", "first word", host_word, w0);
    chk(addr_q == 16'h0103, "R3", "addr +2", addr_q, 16'h0103);
    chk(cnt_q == 16'h0001, "R3", "cnt -2", cnt_q, 1);
    chk(flag_ready && busy && !flag_end, "R3", "ready/busy", {flag_ready, busy, flag_end}, 3'b110);
    hread(1'b1); step(6);
    chk(addr_q == 16'h0103, "R4", "other host ignored", addr_q, 16'h0103);
    hread(1'b0);
    chk(host_word == w0, "R4", "latched at read", host_word, w0);
    step(6);
    chk(host_word == bw(16'h0102), "R4", "prefetched word", host_word, bw(16'h0102));
    chk(cnt_q == 16'hFFFF, "R5", "terminal count", cnt_q, 16'hFFFF);
    chk(!busy && flag_end && flag_ready, "R5", "end flags", {busy, flag_end, flag_ready}, 3'b011);
    chk(end_pend, "R5", "end pending", end_pend, 1);
    chk(addr_q == 16'h0105, "R5", "final addr", addr_q, 16'h0105);
    hread(1'b0); step(4);
    chk(!flag_ready, "R6", "ready cleared", flag_ready, 0);
    chk(addr_q == 16'h0105 && host_word == bw(16'h0102), "R6", "no fetch", addr_q, 16'h0105);
    ack();
  endtask

  task automatic t_wrap();
    load(16'hFFFE, 12'd1); fire(3'd3); step(6);
    chk(host_word == {bb(14'h3FFE), bb(14'h3FFF)}, "R3", "masked word",
        host_word, {bb(14'h3FFE), bb(14'h3FFF)});
    chk(addr_q == 16'h0000, "R3", "addr wrap", addr_q, 0);
    chk(flag_end && cnt_q == 16'hFFFF, "R5", "one-word end", cnt_q, 16'hFFFF);
    ack();
  endtask

  task automatic t_ignore();
    dout_en = 0; nw = 0;
    load(16'h0040, 12'd2); fire(3'd4); step(50);
    chk(flag_end && !busy, "R2", "trigger ignored", {flag_end, busy}, 2'b10);
    chk(nw == 0, "R2", "no writes", nw, 0);
    dout_en = 1; step(2);
  endtask

  task automatic t_invalid(input logic [2:0] code);
    nw = 0;
    load(16'h0040, 12'd5); fire(code); step(50);
    chk(!busy && !flag_end && !flag_ready, "R11", "no start", {busy, flag_end, flag_ready}, 0);
    chk(addr_q == 16'h0040 && cnt_q == 16'd5 && nw == 0, "R11", "untouched", addr_q, 16'h0040);
  endtask

  task automatic t_dma();
    nw = 0; stall = 0;
    load(16'h0200, 12'd10); fire(3'd4); wait_idle();
    chk(nw == 11, "R7", "byte count", nw, 11);
    for (int i = 0; i < 11 && i < nw; i++) begin
      chk(wl_a[i] == 16'h0200 + 16'(i), "R7", "byte addr", wl_a[i], 16'h0200 + 16'(i));
      chk(wl_d[i] == bb(14'(16'h0200 + 16'(i))), "R7", "byte data", wl_d[i], bb(14'(16'h0200 + 16'(i))));
    end
    chk(flag_end && !flag_ready && cnt_q == 16'hFFFF, "R7", "end state", {flag_end, flag_ready}, 2'b10);
    if (nw >= 9) begin
      chk(wl_t[0] - t_trig >= BCYC, "R8", "first burst delay", wl_t[0] - t_trig, BCYC);
      chk(wl_t[7] - wl_t[0] < BCYC, "R8", "burst contiguous", wl_t[7] - wl_t[0], BCYC);
      chk(wl_t[8] - wl_t[0] >= BCYC, "R8", "burst spacing", wl_t[8] - wl_t[0], BCYC);
    end
    ack();
  endtask

  task automatic t_tgt(input logic [2:0] code, input logic split, input logic bsel,
                       input logic [2:0] exp);
    nw = 0; stall = 1; word_split = split; bank_sel = bsel; own_word = split;
    load(16'h0301, 12'd2); fire(code); wait_idle();
    chk(nw == 3, "R9", "bytes", nw, 3);
    chk(wl_g[0] == exp, "R9", "target", wl_g[0], exp);
    chk(wl_d[2] == bb(14'h0303), "R9", "stalled data", wl_d[2], bb(14'h0303));
    stall = 0; own_word = 0; word_split = 0; ack();
  endtask

  task automatic t_halt(input logic [2:0] code);
    nw = 0;
    if (code == 3'd5) own_prg = 1; else own_word = 1;
    load(16'h0400, 12'd3); fire(code); step(80);
    chk(halted && busy && nw == 0, "R10", "parked", {halted, busy}, 2'b11);
    own_prg = 0; own_word = 0; wait_idle();
    chk(!halted && nw == 4 && flag_end, "R10", "resumed", nw, 4);
    ack();
  endtask

  task automatic t_abort();
    int n1;
    nw = 0;
    load(16'h0500, 12'd20); fire(3'd4);
    for (int i = 0; i < 500 && nw < 2; i++) @(negedge clk);
    dout_en = 0; @(negedge clk); n1 = nw; step(60);
    chk(!busy && !flag_end, "R12", "aborted", {busy, flag_end}, 0);
    chk(nw == n1, "R12", "no more writes", nw, n1);
    dout_en = 1; step(2);
  endtask

  task automatic t_irq();
    int e0, d0;
    end_ie = 1; dec_pend = 0; dec_expired = 0;
    e0 = n_edge; load(16'h0010, 12'd0); fire(3'd2); step(6);
    chk(n_edge == e0 + 1 && end_pend, "R13", "edge on end", n_edge - e0, 1);
    e0 = n_edge; load(16'h0010, 12'd0); fire(3'd2); step(6);
    chk(n_edge == e0, "R13", "no edge while unacked", n_edge - e0, 0);
    ack(); step(1);
    chk(!end_pend, "R13", "ack clears", end_pend, 0);
    dec_pend = 1; e0 = n_edge; d0 = n_dclr;
    load(16'h0010, 12'd0); fire(3'd2); step(6);
    chk(n_edge == e0 && n_dclr == d0 && end_pend, "R13", "decoder blocks", n_edge - e0, 0);
    ack(); dec_expired = 1; e0 = n_edge; d0 = n_dclr;
    load(16'h0010, 12'd0); fire(3'd2); step(6);
    chk(n_edge == e0 + 1 && n_dclr == d0 + 1, "R13", "expired decoder cleared", n_dclr - d0, 1);
    ack(); dec_pend = 0; dec_expired = 0; end_ie = 0; e0 = n_edge;
    load(16'h0010, 12'd0); fire(3'd2); step(6);
    chk(n_edge == e0 && end_pend, "R13", "disabled: pend only", n_edge - e0, 0);
    ack();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(4); rst = 0; step(2);
    t_reset();
    t_host();
    t_wrap();
    t_ignore();
    t_invalid(3'd0);
    t_invalid(3'd1);
    t_invalid(3'd6);
    t_dma();
    t_tgt(3'd4, 1'b0, 1'b0, 3'd0);
    t_tgt(3'd5, 1'b0, 1'b0, 3'd1);
    t_tgt(3'd7, 1'b1, 1'b1, 3'd2);
    t_tgt(3'd7, 1'b1, 1'b0, 3'd3);
    t_tgt(3'd7, 1'b0, 1'b0, 3'd4);
    t_halt(3'd5);
    t_halt(3'd7);
    t_abort();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule